// File: doc/BRIEF.md
# Two-Bank Line-Parity Request Dispatcher

This block accepts one stream of memory requests and sends each one to one of two independent cache banks. The bank is chosen by the parity of the cache-line number. Each bank is modelled as a short request queue followed by a service stage, and each bank's service delay is set from an input pin. The two banks work in parallel, so a bank with a short delay can finish a younger request while the other bank is still working on an older one.

Every accepted request gets a sequence tag from a running counter. Completions leave the block on a single output that carries the tag, the bank and the access kind, so an observer can see when requests retire out of program order. A mode input turns on strict ordering. In that mode a finished request waits at the head of its bank until every older request has retired, and completions then appear in tag order.

The block holds no data, keeps no coherence state and has no interconnect. It exists to produce and observe the ordering behaviour of a banked cache.

Top module: `twobank_dispatch`

## Requirements
- R1: Address bit 8 selects the bank (the line size is 256 bytes, so bits 7:0 are the offset within the line). A clear bit goes to bank 0, a set bit goes to bank 1, and `cpl_bank` reports that bit for the completed request.
- R2: Tags start at 0 after reset and rise by one, modulo 2^TAG_W, for each accepted request (`req_valid` and `req_ready` both high at a clock edge). Each completion carries the tag of its own request.
- R3: Completions from one bank appear in the order in which that bank accepted its requests.
- R4: Each bank queue holds DEPTH (4) requests. `req_ready` is low exactly when the queue of the bank addressed by `req_addr` is full, and it does not depend on the other bank. A request that is held off consumes no tag.
- R5: A request accepted while its bank is idle and the output is free shows `cpl_valid` high starting lat+2 clock edges after the accepting edge, where lat is that bank's latency input (`bank_lat0` or `bank_lat1`). The latency input is sampled when the request enters service.
- R6: With strict ordering off, a request to an odd line issued after a request to an even line completes first when bank 0's latency is long and bank 1's is short. This holds for both writes and reads.
- R7: With `in_order` high, each completion's tag is one greater than the previous completion's tag.
- R8: At most one completion leaves per cycle. When both banks finish in the same cycle with strict ordering off, the older tag leaves first and the other leaves on the next cycle.
- R9: During and right after reset, `cpl_valid` is low and `req_ready` is high.
- R10: `cpl_write` returns the `req_write` value (1 = write, 0 = read) of the completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The target bank's queue can take the request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| bank_lat0 | input | LAT_W | Service delay in cycles for bank 0 |
| bank_lat1 | input | LAT_W | Service delay in cycles for bank 1 |
| in_order | input | 1 | 1 = release completions in tag order |
| cpl_valid | output | 1 | A completion is presented this cycle |
| cpl_tag | output | TAG_W | Sequence tag of the completed request |
| cpl_bank | output | 1 | Bank that served the request |
| cpl_write | output | 1 | Access kind of the completed request |

## Verification
`req_ready` is combinational, so it is valid in the same cycle as the address that drives it. A completion is registered and appears lat+2 edges after acceptance: one edge moves the request into service, lat edges count down the delay, and one edge registers the output. Waiting for an older request or for the output to be free delays it further. The bench's behavioural model advances on each rising edge using the inputs the bench drove. The bench drives new inputs at the falling edge and compares every output against the model two time units later, so each sample is taken well clear of both edges. The directed tests for latency and same-cycle ties count falling edges from the accepting edge and expect the counts worked out above.

// File: rtl/twobank_dispatch_pkg.sv
package twobank_dispatch_pkg;
   // The block splits traffic by line parity, so there are exactly two banks.
   localparam int TBD_BANKS = 2;

   // Service stage of one bank.
   typedef enum logic {
      SVC_IDLE = 1'b0,
      SVC_RUN  = 1'b1
   } svc_state_e;
endpackage

// File: rtl/twobank_dispatch_fifo.sv
module twobank_dispatch_fifo #(
   parameter int W     = 7,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("twobank_dispatch_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   assign head  = mem[rd_ptr];
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
endmodule

// File: rtl/twobank_dispatch_bank.sv
module twobank_dispatch_bank
   import twobank_dispatch_pkg::*;
#(
   parameter int TAG_W = 6,
   parameter int DEPTH = 4,
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   input  logic             push_wr,
   input  logic [LAT_W-1:0] lat,
   input  logic             grant,
   output logic             full,
   output logic             head_vld,
   output logic [TAG_W-1:0] head_tag,
   output logic             head_wr,
   output logic             done
);
   localparam int EW = TAG_W + 1;

   logic [EW-1:0]    head_ent;
   logic             empty;
   svc_state_e       state;
   logic [LAT_W-1:0] remain;

   twobank_dispatch_fifo #(.W(EW), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data ({push_wr, push_tag}),
      .pop       (grant),
      .head      (head_ent),
      .full      (full),
      .empty     (empty)
   );

   // Head enters service one edge after it reaches the head, counts down
   // the latency sampled at that moment, then waits until it is granted.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SVC_IDLE;
         remain <= '0;
      end else begin
         case (state)
            SVC_IDLE: begin
               if (!empty) begin
                  state  <= SVC_RUN;
                  remain <= lat;
               end
            end
            SVC_RUN: begin
               if (grant)             state  <= SVC_IDLE;
               else if (remain != '0) remain <= remain - 1'b1;
            end
            default: state <= SVC_IDLE;
         endcase
      end
   end

   assign head_vld = !empty;
   assign head_tag = head_ent[TAG_W-1:0];
   assign head_wr  = head_ent[TAG_W];
   assign done     = (state == SVC_RUN) && (remain == '0);
endmodule

// File: rtl/twobank_dispatch_arb.sv
module twobank_dispatch_arb
   import twobank_dispatch_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic                            in_order,
   input  logic [TBD_BANKS-1:0]            head_vld,
   input  logic [TBD_BANKS-1:0]            done,
   input  logic [TBD_BANKS-1:0][TAG_W-1:0] head_tag,
   output logic [TBD_BANKS-1:0]            grant
);
   for (genvar b = 0; b < TBD_BANKS; b++) begin : g_pick
      localparam int O = TBD_BANKS - 1 - b;
      logic [TAG_W-1:0] gap;
      logic             is_older;
      logic             oldest_head;
      logic             first_done;

      // Modular distance: a small positive gap means the other head is younger.
      assign gap         = head_tag[O] - head_tag[b];
      assign is_older    = !gap[TAG_W-1];
      assign oldest_head = !head_vld[O] || is_older;
      assign first_done  = !done[O] || is_older;
      assign grant[b]    = done[b] && (in_order ? oldest_head : first_done);
   end
endmodule

// File: rtl/twobank_dispatch.sv
module twobank_dispatch
   import twobank_dispatch_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 256,
   parameter int DEPTH      = 4,
   parameter int TAG_W      = 6,
   parameter int LAT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [LAT_W-1:0]  bank_lat0,
   input  logic [LAT_W-1:0]  bank_lat1,
   input  logic              in_order,
   output logic              cpl_valid,
   output logic [TAG_W-1:0]  cpl_tag,
   output logic              cpl_bank,
   output logic              cpl_write
);
   localparam int SEL_BIT = $clog2(LINE_BYTES);

   if ((1 << SEL_BIT) != LINE_BYTES || SEL_BIT >= ADDR_W) begin : g_bad_line
      $error("twobank_dispatch: LINE_BYTES must be a power of two inside the address");
   end
   if ((1 << (TAG_W - 1)) <= TBD_BANKS * DEPTH) begin : g_bad_tag
      $error("twobank_dispatch: TAG_W too narrow for the requests in flight");
   end

   logic                            sel;
   logic                            accept;
   logic [TAG_W-1:0]                next_tag;
   logic [TBD_BANKS-1:0]            full, head_vld, done, grant, head_wr;
   logic [TBD_BANKS-1:0][TAG_W-1:0] head_tag;
   logic [TBD_BANKS-1:0][LAT_W-1:0] lat_v;

   assign sel       = req_addr[SEL_BIT];
   assign req_ready = !full[sel];
   assign accept    = req_valid && req_ready;
   assign lat_v     = {bank_lat1, bank_lat0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      next_tag <= '0;
      else if (accept) next_tag <= next_tag + 1'b1;
   end

   for (genvar b = 0; b < TBD_BANKS; b++) begin : g_bank
      twobank_dispatch_bank #(.TAG_W(TAG_W), .DEPTH(DEPTH), .LAT_W(LAT_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (accept && (sel == 1'(b))),
         .push_tag (next_tag),
         .push_wr  (req_write),
         .lat      (lat_v[b]),
         .grant    (grant[b]),
         .full     (full[b]),
         .head_vld (head_vld[b]),
         .head_tag (head_tag[b]),
         .head_wr  (head_wr[b]),
         .done     (done[b])
      );
   end

   twobank_dispatch_arb #(.TAG_W(TAG_W)) u_arb (
      .in_order (in_order),
      .head_vld (head_vld),
      .done     (done),
      .head_tag (head_tag),
      .grant    (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpl_valid <= 1'b0;
         cpl_tag   <= '0;
         cpl_bank  <= 1'b0;
         cpl_write <= 1'b0;
      end else begin
         cpl_valid <= |grant;
         if (|grant) begin
            cpl_bank  <= grant[1];
            cpl_tag   <= grant[1] ? head_tag[1] : head_tag[0];
            cpl_write <= grant[1] ? head_wr[1]  : head_wr[0];
         end
      end
   end
endmodule

// File: rtl/twobank_dispatch_chk.sv
module twobank_dispatch_chk #(
   parameter int ADDR_W  = 32,
   parameter int DEPTH   = 4,
   parameter int TAG_W   = 6,
   parameter int SEL_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic              in_order,
   input logic              cpl_valid,
   input logic [TAG_W-1:0]  cpl_tag,
   input logic              cpl_bank,
   input logic              cpl_write
);
   localparam int NTAG = 1 << TAG_W;

   logic             sel, acc;
   logic [TAG_W-1:0] issue;
   logic             bank_of [NTAG];
   logic             kind_of [NTAG];
   int               held [2];
   int               occ [2];
   logic [TAG_W-1:0] last_b [2];
   logic             seen_b [2];
   logic             mode_d, clean;
   logic [TAG_W-1:0] last_g;

   assign sel = req_addr[SEL_BIT];
   assign acc = req_valid && req_ready;

   function automatic logic newer(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
      logic [TAG_W-1:0] d;
      d = a - b;
      return (d != '0) && !d[TAG_W-1];
   endfunction

   always_comb begin
      occ[0] = held[0] - ((cpl_valid && !cpl_bank) ? 1 : 0);
      occ[1] = held[1] - ((cpl_valid &&  cpl_bank) ? 1 : 0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue  <= '0;
         held   <= '{0, 0};
         last_b <= '{'0, '0};
         seen_b <= '{1'b0, 1'b0};
         mode_d <= 1'b0;
         clean  <= 1'b0;
         last_g <= '0;
      end else begin
         if (acc) issue <= issue + 1'b1;
         for (int b = 0; b < 2; b++) begin
            held[b] <= held[b] + ((acc && sel == 1'(b)) ? 1 : 0)
                               - ((cpl_valid && cpl_bank == 1'(b)) ? 1 : 0);
         end
         if (cpl_valid) begin
            last_b[cpl_bank] <= cpl_tag;
            seen_b[cpl_bank] <= 1'b1;
            clean            <= mode_d;
            last_g           <= cpl_tag;
         end else if (!mode_d) begin
            clean <= 1'b0;
         end
         mode_d <= in_order;
      end
   end

   always_ff @(posedge clk) begin
      if (acc) begin
         bank_of[issue] <= sel;
         kind_of[issue] <= req_write;
      end
   end

   AST_BANK_STEER: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> cpl_bank == bank_of[cpl_tag]); // R1
   AST_KIND_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> cpl_write == kind_of[cpl_tag]); // R10
   AST_BANK_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && seen_b[cpl_bank]) |-> newer(cpl_tag, last_b[cpl_bank])); // R3
   AST_INORDER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && mode_d && clean) |-> cpl_tag == TAG_W'(last_g + 1'b1)); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ[0] <= DEPTH && occ[1] <= DEPTH); // R4
   AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && occ[sel] == DEPTH) |-> !req_ready); // R4
   AST_READY_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && occ[sel] < DEPTH) |-> req_ready); // R4
endmodule

bind twobank_dispatch twobank_dispatch_chk #(
   .ADDR_W  (ADDR_W),
   .DEPTH   (DEPTH),
   .TAG_W   (TAG_W),
   .SEL_BIT (SEL_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .req_write (req_write),
   .in_order  (in_order),
   .cpl_valid (cpl_valid),
   .cpl_tag   (cpl_tag),
   .cpl_bank  (cpl_bank),
   .cpl_write (cpl_write)
);

// File: tb/twobank_dispatch_test.sv
module twobank_dispatch_test;
   localparam int ADDR_W = 32;
   localparam int DEPTH  = 4;
   localparam int TAG_W  = 6;
   localparam int LAT_W  = 4;
   localparam int TAGM   = 1 << TAG_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic [LAT_W-1:0]  lat0 = '0, lat1 = '0;
   logic              in_order = 1'b0;
   logic              req_ready, cpl_valid, cpl_bank, cpl_write;
   logic [TAG_W-1:0]  cpl_tag;

   always #5 clk = ~clk;

   twobank_dispatch #(.ADDR_W(ADDR_W), .LINE_BYTES(256), .DEPTH(DEPTH),
                      .TAG_W(TAG_W), .LAT_W(LAT_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .bank_lat0(lat0),
      .bank_lat1(lat1), .in_order(in_order), .cpl_valid(cpl_valid),
      .cpl_tag(cpl_tag), .cpl_bank(cpl_bank), .cpl_write(cpl_write));

   int    n_chk = 0, n_fail = 0, cyc = 0, issued = 0;
   bit    ended = 0;
   string phase = "R9";

   // Behavioural reference: per-bank queues of (tag*2 + write).
   int mq0[$], mq1[$];
   bit ms0 = 0, ms1 = 0;
   int mc0 = 0, mc1 = 0, m_tag = 0, mt0, mt1, mtmp;
   bit mh0, mh1, md0, md1, mo0, mg0, mg1, macc;
   bit e_valid = 0, e_bank = 0, e_wr = 0;
   int e_tag = 0;

   int lg_tag[$], lg_bank[$], lg_cyc[$];

   task automatic check(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mq0.delete(); mq1.delete();
         ms0 = 0; ms1 = 0; mc0 = 0; mc1 = 0; m_tag = 0; e_valid = 0;
      end else begin
         mh0 = mq0.size() > 0;
         mh1 = mq1.size() > 0;
         mt0 = mh0 ? (mq0[0] >> 1) : 0;
         mt1 = mh1 ? (mq1[0] >> 1) : 0;
         md0 = ms0 && mc0 == 0;
         md1 = ms1 && mc1 == 0;
         mo0 = ((mt1 - mt0) & (TAGM - 1)) < TAGM / 2;
         if (in_order) begin
            mg0 = md0 && (!mh1 || mo0);
            mg1 = md1 && (!mh0 || !mo0);
         end else begin
            mg0 = md0 && (!md1 || mo0);
            mg1 = md1 && (!md0 || !mo0);
         end
         e_valid = mg0 || mg1;
         if (mg1) begin e_tag = mt1; e_bank = 1; e_wr = mq1[0][0]; end
         else if (mg0) begin e_tag = mt0; e_bank = 0; e_wr = mq0[0][0]; end
         macc = req_valid && ((req_addr[8] ? mq1.size() : mq0.size()) < DEPTH);
         if (mg0) begin mtmp = mq0.pop_front(); ms0 = 0; end
         else if (ms0 && mc0 != 0) mc0--;
         else if (!ms0 && mh0) begin ms0 = 1; mc0 = int'(lat0); end
         if (mg1) begin mtmp = mq1.pop_front(); ms1 = 0; end
         else if (ms1 && mc1 != 0) mc1--;
         else if (!ms1 && mh1) begin ms1 = 1; mc1 = int'(lat1); end
         if (macc) begin
            if (req_addr[8]) mq1.push_back(m_tag * 2 + int'(req_write));
            else             mq0.push_back(m_tag * 2 + int'(req_write));
            m_tag = (m_tag + 1) & (TAGM - 1);
         end
      end
   end

   // Compare every cycle, clear of both clock edges.
   always @(negedge clk) begin
      #2;
      cyc++;
      check(phase, int'(cpl_valid), int'(e_valid), "completion valid");
      if (cpl_valid && e_valid) begin
         check(phase, int'(cpl_tag), e_tag, "completion tag (R2)");
         check(phase, int'(cpl_bank), int'(e_bank), "completion bank (R1)");
         check(phase, int'(cpl_write), int'(e_wr), "completion kind (R10)");
      end
      if (cpl_valid) begin
         lg_tag.push_back(int'(cpl_tag));
         lg_bank.push_back(int'(cpl_bank));
         lg_cyc.push_back(cyc);
      end
      check("R4", int'(req_ready),
            int'((req_addr[8] ? mq1.size() : mq0.size()) < DEPTH), "ready");
   end

   task automatic send(input logic [ADDR_W-1:0] a, input bit w);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_write = w;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      issued++;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic drain();
      idle();
      while (mq0.size() != 0 || mq1.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic measure(input logic [ADDR_W-1:0] a, input bit w, input int lat,
                          input int bank);
      int k;
      int t;
      t = issued;
      send(a, w);
      @(negedge clk);
      req_valid = 0;
      #3;
      k = 1;
      while (!cpl_valid && k < 40) begin @(negedge clk); #3; k++; end
      check("R5", k, lat + 3, "falling edges to completion");
      check("R2", int'(cpl_tag), t % TAGM, "tag of lone request");
      check("R1", int'(cpl_bank), bank, "bank from address bit 8");
      check("R10", int'(cpl_write), int'(w), "kind echoed");
      drain();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R9", int'(cpl_valid), 0, "valid in reset");
      check("R9", int'(req_ready), 1, "ready in reset");
      @(negedge clk);
      rst_n = 1;
      #3;
      check("R9", int'(cpl_valid), 0, "valid after reset");
      check("R9", int'(req_ready), 1, "ready after reset");

      // R5 latency, with R1, R2 and R10 on lone requests
      phase = "R5";
      lat1 = 3;
      measure(32'h1234_5100, 1'b1, 3, 1);
      lat0 = 0;
      measure(32'h1234_5000, 1'b0, 0, 0);
      lat0 = 5;
      measure(32'h0000_0E00, 1'b1, 5, 0);

      // R6: busy even bank, idle odd bank, writes then reads
      for (int rd = 0; rd < 2; rd++) begin
         int te;
         phase = "R6";
         lat0 = 12; lat1 = 1;
         lg_tag.delete(); lg_bank.delete(); lg_cyc.delete();
         te = issued % TAGM;
         send(32'h1234_5000, rd == 0);
         send(32'h1234_5100, rd == 0);
         drain();
         check("R6", lg_tag.size(), 2, "completions seen");
         if (lg_tag.size() == 2) begin
            check("R6", lg_tag[0], (te + 1) % TAGM, "odd line retires first");
            check("R6", lg_tag[1], te, "even line retires second");
         end
      end

      // R8: both banks finish on the same cycle, older leaves first
      begin
         int te;
         phase = "R8";
         lat0 = 3; lat1 = 2;
         lg_tag.delete(); lg_bank.delete(); lg_cyc.delete();
         te = issued % TAGM;
         send(32'h0000_0200, 1'b1);
         send(32'h0000_0300, 1'b0);
         drain();
         check("R8", lg_tag.size(), 2, "completions seen");
         if (lg_tag.size() == 2) begin
            check("R8", lg_tag[0], te, "older tag wins the tie");
            check("R8", lg_tag[1], (te + 1) % TAGM, "younger tag follows");
            check("R8", lg_cyc[1] - lg_cyc[0], 1, "one completion per cycle");
         end
      end

      // R4 and R3: fill bank 0, probe both banks, then a held fifth request
      begin
         int tb;
         phase = "R4";
         lat0 = 8; lat1 = 0;
         lg_tag.delete(); lg_bank.delete(); lg_cyc.delete();
         tb = issued % TAGM;
         for (int i = 0; i < 4; i++) send(32'h0000_0000 + 32'(i) * 32'h200, i[0]);
         @(negedge clk);
         req_valid = 0; req_addr = 32'h0000_0800;
         #1;
         check("R4", int'(req_ready), 0, "full bank 0 refuses");
         req_addr = 32'h0000_0900;
         #1;
         check("R4", int'(req_ready), 1, "bank 1 still open");
         req_valid = 1; req_addr = 32'h0000_0800; req_write = 1;
         send(32'h0000_0800, 1'b1);
         drain();
         check("R3", lg_tag.size(), 5, "completions seen");
         for (int i = 0; i < lg_tag.size(); i++)
            check("R3", lg_tag[i], (tb + i) % TAGM, "bank 0 FIFO order");
         if (lg_tag.size() == 5)
            check("R4", lg_tag[4], (tb + 4) % TAGM, "held request took next tag");
      end

      // R7: strict ordering holds back the fast odd bank
      begin
         int t0;
         phase = "R7";
         in_order = 1;
         lat0 = 9; lat1 = 0;
         lg_tag.delete(); lg_bank.delete(); lg_cyc.delete();
         t0 = issued % TAGM;
         send(32'h0000_1000, 1'b1);
         send(32'h0000_1100, 1'b1);
         send(32'h0000_1300, 1'b0);
         send(32'h0000_1400, 1'b1);
         send(32'h0000_1500, 1'b0);
         send(32'h0000_1700, 1'b1);
         drain();
         check("R7", lg_tag.size(), 6, "completions seen");
         for (int i = 0; i < lg_tag.size(); i++)
            check("R7", lg_tag[i], (t0 + i) % TAGM, "tag order");
         in_order = 0;
      end

      // Mixed traffic in both modes against the model (R2, R3, R7)
      for (int burst = 0; burst < 6; burst++) begin
         int n0;
         phase = "R2";
         in_order = burst[0];
         lat0 = LAT_W'($urandom % 8);
         lat1 = LAT_W'($urandom % 8);
         lg_tag.delete(); lg_bank.delete(); lg_cyc.delete();
         n0 = issued;
         for (int i = 0; i < 40; i++) begin
            if ($urandom % 4 == 0) idle();
            send($urandom & 32'hFFFF_FF00, 1'($urandom));
         end
         drain();
         check("R2", lg_tag.size(), issued - n0, "every request retired");
         for (int i = 1; i < lg_tag.size(); i++) begin
            if (burst[0])
               check("R7", lg_tag[i], (lg_tag[i-1] + 1) % TAGM, "burst tag order");
         end
      end

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished (cycle %0d)", cyc);
      finish_run();
   end
endmodule